// File: doc/BRIEF.md
# Decimal matrix code encoder

This block computes the check bits that protect one 32-bit memory word against upsets hitting several neighbouring cells. The word is read as eight 4-bit symbols, placed logically in a matrix of two rows and four columns. Two kinds of redundancy are formed. Horizontal check bits are unsigned integer sums of symbol pairs in one row. Vertical check bits are XOR parities over the bits that share a column position in the two rows.

The write path of a protected memory presents a data word with a valid strobe. One clock later the block returns the data bits unchanged, together with 20 horizontal and 16 vertical check bits. These 68 bits are the stored codeword. The sizes come from package constants: symbol width, row count and column count. The column count must be even, so that every row splits into pairs that are half a row apart.

Top module: `dmc_enc_top`

## Requirements
- R1: While reset is high and after it is released with no valid input, `cw_valid` is 0 and `cw_info`, `cw_hchk` and `cw_vchk` are all zero.
- R2: `cw_valid` is high in the cycle after a clock edge that samples `wr_valid` high, and low in the cycle after an edge that samples it low.
- R3: `cw_info` equals the `wr_data` captured at the last edge where `wr_valid` was high.
- R4: Symbol i is `wr_data[4i+3:4i]`, read as an unsigned integer. `cw_hchk[4:0]` = sym0 + sym2 and `cw_hchk[9:5]` = sym1 + sym3. Each sum is 5 bits wide and keeps its carry, so the largest value is 30.
- R5: `cw_hchk[14:10]` = sym4 + sym6 and `cw_hchk[19:15]` = sym5 + sym7, with the same 5-bit unsigned rule as R4.
- R6: `cw_vchk[j]` = `wr_data[j]` XOR `wr_data[j+16]` for j = 0..15.
- R7: At an edge where `wr_valid` is low, `cw_info`, `cw_hchk` and `cw_vchk` keep their values, whatever `wr_data` carries.
- R8: Back-to-back valid words produce back-to-back codewords, each one belonging to the word sampled one edge earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| wr_valid | input | 1 | Data word present on `wr_data` |
| wr_data | input | 32 | Data word to encode |
| cw_valid | output | 1 | Codeword outputs hold a fresh word |
| cw_info | output | 32 | Information bits, equal to the captured data |
| cw_hchk | output | 20 | Four 5-bit horizontal sums |
| cw_vchk | output | 16 | Vertical XOR check bits |

## Verification
The clocked properties assume that `wr_valid` and `wr_data` are settled before each rising edge. They also assume that reset is held for at least one edge, so that `$past` refers to sampled values. The bench changes inputs only on the falling edge and holds reset for several cycles. Through the hold tests it deliberately puts changing data on `wr_data` while `wr_valid` is low. This covers the case the hold property guards. Data patterns include all-zero and all-ones words, words whose sums carry into the top bit, and walking bits that cross the two matrix rows.

// File: rtl/dmc_pkg.sv
package dmc_pkg;

    // Default matrix geometry: symbol width, rows and columns.
    localparam int DMC_SYM_W = 4;
    localparam int DMC_ROWS  = 2;
    localparam int DMC_COLS  = 4;

    // Distance in columns between the two symbols added for one sum.
    function automatic int pair_span(input int cols);
        return cols / 2;
    endfunction

    // Width of one horizontal sum: one carry bit above the symbol.
    function automatic int sum_width(input int sym_w);
        return sym_w + 1;
    endfunction

endpackage

// File: rtl/dmc_hsum.sv
module dmc_hsum
    import dmc_pkg::*;
#(
    parameter int SYM_W = DMC_SYM_W,
    parameter int ROWS  = DMC_ROWS,
    parameter int COLS  = DMC_COLS,
    localparam int DATA_W = SYM_W * ROWS * COLS,
    localparam int HALF   = pair_span(COLS),
    localparam int SUM_W  = sum_width(SYM_W),
    localparam int H_W    = ROWS * HALF * SUM_W
) (
    input  logic [DATA_W-1:0] data,
    output logic [H_W-1:0]    hchk
);

    // One adder per symbol pair: left half of a row plus right half.
    for (genvar r = 0; r < ROWS; r++) begin : g_row
        for (genvar p = 0; p < HALF; p++) begin : g_pair
            localparam int LO_SYM = r * COLS + p;
            localparam int HI_SYM = LO_SYM + HALF;
            localparam int SLOT   = r * HALF + p;

            logic [SUM_W-1:0] lo_ext;
            logic [SUM_W-1:0] hi_ext;

            always_comb begin
                lo_ext = {1'b0, data[LO_SYM*SYM_W +: SYM_W]};
                hi_ext = {1'b0, data[HI_SYM*SYM_W +: SYM_W]};
                hchk[SLOT*SUM_W +: SUM_W] = lo_ext + hi_ext;
            end
        end
    end

endmodule

// File: rtl/dmc_vpar.sv
module dmc_vpar
    import dmc_pkg::*;
#(
    parameter int SYM_W = DMC_SYM_W,
    parameter int ROWS  = DMC_ROWS,
    parameter int COLS  = DMC_COLS,
    localparam int DATA_W = SYM_W * ROWS * COLS,
    localparam int V_W    = SYM_W * COLS
) (
    input  logic [DATA_W-1:0] data,
    output logic [V_W-1:0]    vchk
);

    // Each bit position of a row is folded over all rows.
    for (genvar j = 0; j < V_W; j++) begin : g_col
        logic [ROWS-1:0] column;

        for (genvar r = 0; r < ROWS; r++) begin : g_tap
            assign column[r] = data[r*V_W + j];
        end

        assign vchk[j] = ^column;
    end

endmodule

// File: rtl/dmc_enc_top.sv
module dmc_enc_top
    import dmc_pkg::*;
#(
    parameter int SYM_W = DMC_SYM_W,
    parameter int ROWS  = DMC_ROWS,
    parameter int COLS  = DMC_COLS,
    localparam int DATA_W = SYM_W * ROWS * COLS,
    localparam int HALF   = pair_span(COLS),
    localparam int SUM_W  = sum_width(SYM_W),
    localparam int H_W    = ROWS * HALF * SUM_W,
    localparam int V_W    = SYM_W * COLS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    output logic              cw_valid,
    output logic [DATA_W-1:0] cw_info,
    output logic [H_W-1:0]    cw_hchk,
    output logic [V_W-1:0]    cw_vchk
);

    typedef struct packed {
        logic [V_W-1:0]    vchk;
        logic [H_W-1:0]    hchk;
        logic [DATA_W-1:0] info;
    } codeword_t;

    codeword_t cw_next;
    codeword_t cw_q;
    logic      valid_q;

    dmc_hsum #(.SYM_W(SYM_W), .ROWS(ROWS), .COLS(COLS)) u_hsum (
        .data (wr_data),
        .hchk (cw_next.hchk)
    );

    dmc_vpar #(.SYM_W(SYM_W), .ROWS(ROWS), .COLS(COLS)) u_vpar (
        .data (wr_data),
        .vchk (cw_next.vchk)
    );

    assign cw_next.info = wr_data;

    // The codeword is loaded only for a valid word and held otherwise.
    always_ff @(posedge clk) begin
        if (rst) begin
            cw_q    <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= wr_valid;
            if (wr_valid) begin
                cw_q <= cw_next;
            end
        end
    end

    assign cw_valid = valid_q;
    assign cw_info  = cw_q.info;
    assign cw_hchk  = cw_q.hchk;
    assign cw_vchk  = cw_q.vchk;

endmodule

// File: rtl/dmc_enc_chk.sv
module dmc_enc_chk
    import dmc_pkg::*;
#(
    parameter int SYM_W = DMC_SYM_W,
    parameter int ROWS  = DMC_ROWS,
    parameter int COLS  = DMC_COLS,
    localparam int DATA_W = SYM_W * ROWS * COLS,
    localparam int HALF   = pair_span(COLS),
    localparam int SUM_W  = sum_width(SYM_W),
    localparam int H_W    = ROWS * HALF * SUM_W,
    localparam int V_W    = SYM_W * COLS
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_valid,
    input logic [DATA_W-1:0] wr_data,
    input logic              cw_valid,
    input logic [DATA_W-1:0] cw_info,
    input logic [H_W-1:0]    cw_hchk,
    input logic [V_W-1:0]    cw_vchk
);

    // Reference values for the first sum of each row, taken from the input.
    logic [SUM_W-1:0] ref_row0;
    logic [SUM_W-1:0] ref_row1;
    logic [V_W-1:0]   ref_vert;

    assign ref_row0 = {1'b0, wr_data[0 +: SYM_W]}
                    + {1'b0, wr_data[HALF*SYM_W +: SYM_W]};
    assign ref_row1 = {1'b0, wr_data[COLS*SYM_W +: SYM_W]}
                    + {1'b0, wr_data[(COLS+HALF)*SYM_W +: SYM_W]};
    assign ref_vert = wr_data[0 +: V_W] ^ wr_data[V_W +: V_W];

    p_valid_up_r2: assert property (@(posedge clk) disable iff (rst)
        wr_valid |=> cw_valid);

    p_valid_down_r2: assert property (@(posedge clk) disable iff (rst)
        !wr_valid |=> !cw_valid);

    p_info_pass_r3: assert property (@(posedge clk) disable iff (rst)
        wr_valid |=> cw_info == $past(wr_data));

    p_row0_sum_r4: assert property (@(posedge clk) disable iff (rst)
        wr_valid |=> cw_hchk[0 +: SUM_W] == $past(ref_row0));

    p_row1_sum_r5: assert property (@(posedge clk) disable iff (rst)
        wr_valid |=> cw_hchk[HALF*SUM_W +: SUM_W] == $past(ref_row1));

    p_vert_par_r6: assert property (@(posedge clk) disable iff (rst)
        wr_valid |=> cw_vchk == $past(ref_vert));

    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !wr_valid |=> ($stable(cw_info) && $stable(cw_hchk) && $stable(cw_vchk)));

endmodule

bind dmc_enc_top dmc_enc_chk #(.SYM_W(SYM_W), .ROWS(ROWS), .COLS(COLS)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .wr_valid (wr_valid),
    .wr_data  (wr_data),
    .cw_valid (cw_valid),
    .cw_info  (cw_info),
    .cw_hchk  (cw_hchk),
    .cw_vchk  (cw_vchk)
);

// File: tb/dmc_enc_top_bench.sv
module dmc_enc_top_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_valid = 1'b0;
    logic [31:0] wr_data = '0;
    logic        cw_valid;
    logic [31:0] cw_info;
    logic [19:0] cw_hchk;
    logic [15:0] cw_vchk;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dmc_enc_top u_dmc_enc_top (
        .clk      (clk),
        .rst      (rst),
        .wr_valid (wr_valid),
        .wr_data  (wr_data),
        .cw_valid (cw_valid),
        .cw_info  (cw_info),
        .cw_hchk  (cw_hchk),
        .cw_vchk  (cw_vchk)
    );

    // Expected values written out from the requirements.
    function automatic logic [4:0] add4(input logic [3:0] a, input logic [3:0] b);
        return {1'b0, a} + {1'b0, b};
    endfunction

    function automatic logic [19:0] exp_h(input logic [31:0] d);
        return {add4(d[23:20], d[31:28]), add4(d[19:16], d[27:24]),
                add4(d[7:4],   d[15:12]), add4(d[3:0],   d[11:8])};
    endfunction

    function automatic logic [15:0] exp_v(input logic [31:0] d);
        logic [15:0] v;
        for (int j = 0; j < 16; j++) v[j] = d[j] ^ d[j+16];
        return v;
    endfunction

    task automatic check(input logic ok, input string req,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_word(input logic [31:0] d, input string tag);
        check(cw_valid === 1'b1, {"R2 valid ", tag}, 64'(cw_valid), 64'd1);
        check(cw_info === d, {"R3 info ", tag}, 64'(cw_info), 64'(d));
        check(cw_hchk[9:0] === exp_h(d)[9:0], {"R4 row0 sums ", tag},
              64'(cw_hchk[9:0]), 64'(exp_h(d)[9:0]));
        check(cw_hchk[19:10] === exp_h(d)[19:10], {"R5 row1 sums ", tag},
              64'(cw_hchk[19:10]), 64'(exp_h(d)[19:10]));
        check(cw_vchk === exp_v(d), {"R6 vertical ", tag},
              64'(cw_vchk), 64'(exp_v(d)));
    endtask

    // Presents one word for one edge, then samples after that edge.
    task automatic encode_one(input logic [31:0] d, input string tag);
        @(negedge clk);
        wr_valid = 1'b1;
        wr_data  = d;
        @(posedge clk);
        #1;
        check_word(d, tag);
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic t_reset;
        @(negedge clk);
        check(cw_valid === 1'b0, "R1 valid in reset", 64'(cw_valid), 64'd0);
        check(cw_info === '0 && cw_hchk === '0 && cw_vchk === '0,
              "R1 codeword in reset", {cw_info, 12'd0, cw_hchk}, 64'd0);
        rst = 1'b0;
        @(posedge clk);
        #1;
        check(cw_valid === 1'b0, "R1 valid after release", 64'(cw_valid), 64'd0);
        check(cw_info === '0, "R1 info after release", 64'(cw_info), 64'd0);
    endtask

    task automatic t_patterns;
        encode_one(32'h0000_0000, "zero");
        encode_one(32'hFFFF_FFFF, "ones carry");
        encode_one(32'h0F0F_F0F0, "mixed carry");
        encode_one(32'h1234_5678, "counting");
        encode_one(32'h8000_0001, "row edges");
    endtask

    task automatic t_carry_max;
        encode_one(32'hFFFF_FFFF, "max");
        check(cw_hchk === {4{5'd30}}, "R4 R5 max sum thirty",
              64'(cw_hchk), 64'({4{5'd30}}));
    endtask

    task automatic t_walking;
        for (int b = 0; b < 32; b += 5) begin
            encode_one(32'd1 << b, $sformatf("walk%0d", b));
        end
    endtask

    task automatic t_valid_drop;
        encode_one(32'hA5A5_3C3C, "before drop");
        @(posedge clk);
        #1;
        check(cw_valid === 1'b0, "R2 valid drops", 64'(cw_valid), 64'd0);
    endtask

    task automatic t_hold;
        logic [31:0] kept;
        kept = 32'hDEAD_BEEF;
        encode_one(kept, "hold base");
        wr_data = 32'h1357_9BDF;
        @(posedge clk);
        @(negedge clk);
        wr_data = 32'h2468_ACE0;
        @(posedge clk);
        #1;
        check(cw_info === kept, "R7 info held", 64'(cw_info), 64'(kept));
        check(cw_hchk === exp_h(kept), "R7 hchk held",
              64'(cw_hchk), 64'(exp_h(kept)));
        check(cw_vchk === exp_v(kept), "R7 vchk held",
              64'(cw_vchk), 64'(exp_v(kept)));
    endtask

    task automatic t_burst;
        logic [31:0] words [4];
        words[0] = 32'h0123_4567;
        words[1] = 32'h89AB_CDEF;
        words[2] = 32'hF0E1_D2C3;
        words[3] = 32'h7777_8888;
        @(negedge clk);
        wr_valid = 1'b1;
        wr_data  = words[0];
        for (int i = 0; i < 4; i++) begin
            @(posedge clk);
            #1;
            check_word(words[i], $sformatf("R8 burst%0d", i));
            @(negedge clk);
            if (i < 3) wr_data = words[i+1];
            else       wr_valid = 1'b0;
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        t_reset();
        t_patterns();
        t_carry_max();
        t_walking();
        t_valid_drop();
        t_hold();
        t_burst();
        repeat (2) @(posedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule